// File: doc/BRIEF.md
# Shared-Pin GPIO Port Controller

This block is an eight-pin general-purpose I/O port whose pins may be handed over, one by one, to an external bus-control function. Software configures the port through a small register bus. The registers hold an output value, a direction per pin, a mask of pins claimed by bus control, a global pull-up enable and a reduced-drive control. From this state the block drives the pad ring: a per-pin output enable and output value, per-pin pull-up requests, a reduced-drive flag and a per-pin select that hands the pad to bus control.

Pad levels come back through a synchronizer. A read of the data register gives, for each pin, either the value the port drives or the synchronized pad level. Pins 1 and 0 can only be inputs. The drive-strength control can be written only once after reset. While the mode input selects peripheral operation, the port registers are hidden from the bus. Only the bus-control claim mask stays visible.

Top module: `gpio_bus_port`

## Requirements
- R1: After reset these all read zero: the data, direction, claim mask, pull-up enable and reduced-drive registers. These outputs are also zero: `pad_oe`, `pad_pull`, `pad_low_drive` and `pad_bus_sel`.
- R2: Register map. Offset 0 is data, 1 is direction, 2 is claim mask, 3 is pull-up enable (bit 0) and 4 is reduced drive (bit 0). Other offsets read zero and ignore writes.
- R3: Direction bit n set (1 = output) asserts `pad_oe[n]` for pins 7..2 one cycle after the write. `pad_oe[1:0]` stays 0 whatever the direction bits hold.
- R4: A set claim-mask bit forces `pad_oe[n]` to 0 and `pad_bus_sel[n]` to 1, whatever the direction bit holds.
- R5: While pull-up enable is 1, `pad_pull` equals 8'h8F (pins 7, 3, 2, 1, 0). Otherwise it is 8'h00.
- R6: `pad_low_drive` follows the reduced-drive bit. Only the first accepted write after reset stores it, even when that write stores 0. Later writes are ignored until the next reset.
- R7: While `periph_mode` is 1, reads of offsets 0, 1, 3 and 4 return 0 and writes to them are discarded. A discarded write does not use up the single reduced-drive write.
- R8: `pad_out` equals the data register, updated one cycle after a write.
- R9: A data read returns the data bit for pins whose `pad_oe` is 1. For all other pins it returns the pad level after two clock edges of synchronization.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_mode | input | 1 | Hides the port registers from the bus |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| pad_in | input | 8 | Pad levels, asynchronous |
| pad_out | output | 8 | Output values to pads |
| pad_oe | output | 8 | Port output enables |
| pad_pull | output | 8 | Pull-up requests |
| pad_low_drive | output | 1 | Reduced drive for all port outputs |
| pad_bus_sel | output | 8 | Pins handed to bus control |

## Verification
Register writes are sampled at a rising edge, so their effect on every pad output and on read data is due at the next edge. A change on `pad_in` reaches `reg_rdata` only after the second rising edge. The bench runs a behavioural model that is updated at each rising edge. It compares all outputs against that model at the following edge, before the model absorbs that edge's inputs. The directed checks sample at the falling edge right after the cycle in which a result is due. They also check one edge early for the synchronizer delay.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int PORT_W = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        OFS_DATA  = 3'd0,
        OFS_DIR   = 3'd1,
        OFS_CLAIM = 3'd2,
        OFS_PULL  = 3'd3,
        OFS_DRIVE = 3'd4
    } port_ofs_e;

    typedef struct packed {
        logic [PORT_W-1:0] data;
        logic [PORT_W-1:0] dir;
        logic [PORT_W-1:0] claim;
        logic              pull_en;
        logic              low_drive;
        logic              drive_locked;
    } port_state_t;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_q [STAGES];
    logic [W-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) stage_d[i] = stage_q[i-1];
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

    // R9: the last stage carries what the stage before it held one edge earlier
    a_r9_sync_shift: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> stage_q[STAGES-1] == $past(stage_q[STAGES-2]));
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              periph_mode,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [PORT_W-1:0] reg_wdata,
    output port_state_t       state
);
    port_state_t st_d, st_q;
    logic        hidden;

    always_comb begin
        hidden = periph_mode && (reg_addr != OFS_CLAIM);
        st_d   = st_q;
        if (reg_wr && !hidden) begin
            case (reg_addr)
                OFS_DATA:  st_d.data  = reg_wdata;
                OFS_DIR:   st_d.dir   = reg_wdata;
                OFS_CLAIM: st_d.claim = reg_wdata;
                OFS_PULL:  st_d.pull_en = reg_wdata[0];
                OFS_DRIVE: begin
                    if (!st_q.drive_locked) begin
                        st_d.low_drive    = reg_wdata[0];
                        st_d.drive_locked = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign state = st_q;

    // R6: once a drive write has landed, the drive bit never moves again
    a_r6_drive_locked: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.drive_locked |=> $stable(st_q.low_drive) && st_q.drive_locked);

    // R7: a direction write in peripheral mode leaves the register untouched
    a_r7_hidden_discard: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_mode && reg_wr && reg_addr == OFS_DIR) |=> $stable(st_q.dir));

    // R7: a hidden drive write does not lock the drive control
    a_r7_lock_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_mode && !st_q.drive_locked) |=> !$rose(st_q.drive_locked));
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
    import gpio_port_pkg::*;
#(
    parameter logic [PORT_W-1:0] OUT_CAPABLE = 8'hFC,
    parameter logic [PORT_W-1:0] PULL_PINS   = 8'h8F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  port_state_t       state,
    input  logic [PORT_W-1:0] pin_sync,
    input  logic              periph_mode,
    input  logic [ADDR_W-1:0] reg_addr,
    output logic [PORT_W-1:0] reg_rdata,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] pad_pull,
    output logic              pad_low_drive,
    output logic [PORT_W-1:0] pad_bus_sel
);
    logic [PORT_W-1:0] pin_view;

    always_comb begin
        pad_oe        = state.dir & OUT_CAPABLE & ~state.claim;
        pad_out       = state.data;
        pad_bus_sel   = state.claim;
        pad_pull      = state.pull_en ? PULL_PINS : '0;
        pad_low_drive = state.low_drive;
        for (int i = 0; i < PORT_W; i++)
            pin_view[i] = pad_oe[i] ? state.data[i] : pin_sync[i];
        reg_rdata = '0;
        case (reg_addr)
            OFS_DATA:  if (!periph_mode) reg_rdata = pin_view;
            OFS_DIR:   if (!periph_mode) reg_rdata = state.dir;
            OFS_CLAIM: reg_rdata = state.claim;
            OFS_PULL:  if (!periph_mode) reg_rdata = {{(PORT_W-1){1'b0}}, state.pull_en};
            OFS_DRIVE: if (!periph_mode) reg_rdata = {{(PORT_W-1){1'b0}}, state.low_drive};
            default:   reg_rdata = '0;
        endcase
    end

    // R4: a claimed pin is never driven by the port
    a_r4_claim_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & pad_bus_sel) == '0);

    // R3: an enable only appears on a pin whose direction bit is set
    a_r3_oe_needs_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~state.dir) == '0);

    // R7: hidden registers read as zero in peripheral mode
    a_r7_hidden_read: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_mode && reg_addr != OFS_CLAIM) |-> reg_rdata == '0);
endmodule

// File: rtl/gpio_bus_port.sv
module gpio_bus_port
    import gpio_port_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [PORT_W-1:0] OUT_CAPABLE = 8'hFC,
    parameter logic [PORT_W-1:0] PULL_PINS   = 8'h8F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              periph_mode,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [PORT_W-1:0] reg_wdata,
    output logic [PORT_W-1:0] reg_rdata,
    input  logic [PORT_W-1:0] pad_in,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] pad_pull,
    output logic              pad_low_drive,
    output logic [PORT_W-1:0] pad_bus_sel
);
    port_state_t       state;
    logic [PORT_W-1:0] pin_sync;

    gpio_in_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(pin_sync)
    );

    gpio_port_regs u_regs (
        .clk(clk), .rst_n(rst_n), .periph_mode(periph_mode),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .state(state)
    );

    gpio_pad_ctrl #(.OUT_CAPABLE(OUT_CAPABLE), .PULL_PINS(PULL_PINS)) u_pad (
        .clk(clk), .rst_n(rst_n), .state(state), .pin_sync(pin_sync),
        .periph_mode(periph_mode), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull(pad_pull),
        .pad_low_drive(pad_low_drive), .pad_bus_sel(pad_bus_sel)
    );
endmodule

// File: tb/gpio_bus_port_tb.sv
module gpio_bus_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       periph_mode = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] pad_in = '0;
    logic [7:0] reg_rdata, pad_out, pad_oe, pad_pull, pad_bus_sel;
    logic       pad_low_drive;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    gpio_bus_port u_dut (
        .clk(clk), .rst_n(rst_n), .periph_mode(periph_mode),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_pull(pad_pull), .pad_low_drive(pad_low_drive),
        .pad_bus_sel(pad_bus_sel)
    );

    // behavioural reference
    int m_regs[5];
    bit m_lock;
    int pad_hist[$];

    function automatic int exp_oe();
        return m_regs[1] & 'hFC & ~m_regs[2] & 'hFF;
    endfunction

    function automatic int exp_rd(int a);
        int oe;
        int seen;
        seen = pad_hist[0];
        oe = exp_oe();
        if (periph_mode && a != 2) return 0;
        case (a)
            0: return ((m_regs[0] & oe) | (seen & ~oe)) & 'hFF;
            1, 2: return m_regs[a];
            3, 4: return m_regs[a] & 1;
            default: return 0;
        endcase
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_regs[i]) m_regs[i] = 0;
            m_lock = 0;
            pad_hist = {0, 0};
        end else begin
            chk("R3/R4 oe", pad_oe, exp_oe());
            chk("R8 out", pad_out, m_regs[0]);
            chk("R5 pull", pad_pull, (m_regs[3] & 1) ? 'h8F : 0);
            chk("R6 drive", pad_low_drive, m_regs[4] & 1);
            chk("R4 bus_sel", pad_bus_sel, m_regs[2]);
            chk("R9/R7/R2 rdata", reg_rdata, exp_rd(reg_addr));
            if (reg_wr && !(periph_mode && reg_addr != 2)) begin
                if (reg_addr == 4) begin
                    if (!m_lock) begin m_regs[4] = reg_wdata & 1; m_lock = 1; end
                end else if (reg_addr < 4) begin
                    m_regs[reg_addr] = (reg_addr == 3) ? (reg_wdata & 1) : reg_wdata;
                end
            end
            void'(pad_hist.pop_front());
            pad_hist.push_back(pad_in);
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk);
        reg_addr = a[2:0]; reg_wdata = d[7:0]; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(int a, int exp, string tag);
        reg_addr = a[2:0];
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        do_reset();
        // R1
        chk("R1 oe", pad_oe, 0); chk("R1 pull", pad_pull, 0);
        chk("R1 drive", pad_low_drive, 0); chk("R1 bus_sel", pad_bus_sel, 0);
        for (int a = 0; a < 5; a++) rd(a, 0, "R1 reg reset");
        // R3 R8
        wr(1, 'hFF); wr(0, 'hA5);
        chk("R3 low pins input only", pad_oe, 'hFC);
        chk("R8 pad_out", pad_out, 'hA5);
        rd(1, 'hFF, "R2 dir readback");
        // R9 latency
        rd(0, 'hA4, "R9 inputs low");
        @(negedge clk); pad_in = 'hFF;
        @(negedge clk); rd(0, 'hA4, "R9 one edge early");
        @(negedge clk); rd(0, 'hA7, "R9 after two edges");
        // R4
        wr(2, 'hF0);
        chk("R4 oe claimed", pad_oe, 'h0C);
        chk("R4 bus_sel", pad_bus_sel, 'hF0);
        rd(0, 'hF7, "R9 claimed pins read pad");
        // R5
        wr(3, 1); chk("R5 pull on", pad_pull, 'h8F);
        wr(3, 0); chk("R5 pull off", pad_pull, 0);
        wr(3, 1);
        // R6 first write stores zero
        wr(4, 0); wr(4, 1);
        chk("R6 second write ignored", pad_low_drive, 0);
        rd(4, 0, "R6 readback");
        // R2 unused offsets
        wr(6, 'hFF); rd(6, 0, "R2 unused offset");
        // R7
        @(negedge clk); periph_mode = 1'b1;
        rd(0, 0, "R7 data hidden"); rd(1, 0, "R7 dir hidden");
        rd(3, 0, "R7 pull hidden"); rd(2, 'hF0, "R7 claim visible");
        wr(1, 'h00); wr(0, 'h00);
        @(negedge clk); periph_mode = 1'b0;
        chk("R7 dir write discarded", pad_oe, 'h0C);
        chk("R7 data write discarded", pad_out, 'hA5);
        // R6/R7 hidden drive write keeps the single write
        do_reset();
        @(negedge clk); periph_mode = 1'b1;
        wr(4, 1);
        @(negedge clk); periph_mode = 1'b0;
        chk("R7 hidden drive write", pad_low_drive, 0);
        wr(4, 1); chk("R6 first write taken", pad_low_drive, 1);
        wr(4, 0); chk("R6 locked", pad_low_drive, 1);
        // R3 alternating pattern
        wr(1, 'h55); chk("R3 pattern", pad_oe, 'h54);
        repeat (3) @(negedge clk);
        summary();
    end
endmodule